// File: doc/BRIEF.md
# Processor INIT request generator

This block drives the processor's active-low initialization line. Four sources can start a pulse: a decoded shutdown special cycle, two host I/O write ports, and an active-low reset request from the keyboard controller. One host port is the fast-init port and the other is the reset-control port. When a source fires while the line is idle, the line goes low for a fixed number of clocks and then returns high. The block keeps a copy of the last byte written to each of its two I/O ports. This lets it qualify each write against the previous value, so a pulse starts only when a control bit actually turns on.

The reset-control port also carries a full-reset request. On that request the block raises a one-cycle reset strobe and latches the self-test enable input beside it, so the reset sequencer knows whether built-in self-test was asked for.

The keyboard-controller input is asynchronous. It is synchronized first and then used as a level. Each time it fires it disarms itself, and it is re-armed only once the synchronized input is seen high again.

There is no data stream through this block. Every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. A write is taken in the cycle its strobe is high.

Top module: `init_req_gen`

## Requirements
- R1: After reset, `init_n` is 1, `cpu_rst_req` is 0 and `cpu_rst_bist` is 0. Both port copies are 0, and the keyboard-controller source is armed.
- R2: If `shutdown_cyc` is high at a clock edge while `init_n` is high, `init_n` is low from that edge on.
- R3: A write to FAST_PORT (default 0x0092) starts a pulse at its clock edge only when data bit 0 is 1 and bit 0 of the stored copy is 0.
- R4: A write to RSTC_PORT (default 0x0CF9) starts a pulse only when all three of these hold: data bit 2 is 1 while the stored bit 2 is 0, data bit 1 is 0, and data bit 3 is 0.
- R5: A write to RSTC_PORT where bit 2 rises against the stored copy and data bit 3 is 1 is a full-reset request. It starts no pulse. `cpu_rst_req` is high for exactly the one cycle after that edge. In the same cycle `cpu_rst_bist` takes the value `bist_en` had at that edge, and it holds that value until the next full-reset request.
- R6: `kbc_rst_n` passes through a two-flop synchronizer. If it goes low between edges and stays low, `init_n` is still high after two edges and low after the third.
- R7: After the keyboard-controller source has fired, it stays disarmed however long the input is held low. It fires again only after the synchronized input has been seen high.
- R8: Every pulse keeps `init_n` low for exactly PULSE_LEN (default 16) consecutive clocks.
- R9: A trigger that arrives while `init_n` is low is dropped. It does not lengthen the pulse and does not start another pulse afterwards. A keyboard-controller fire that is dropped this way still disarms that source.
- R10: Every write to FAST_PORT or RSTC_PORT updates that port's stored copy, including writes that start no pulse and writes that are dropped. Writes to any other address change no stored copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Host I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | Host I/O write address |
| io_wdata | input | DATA_W | Host I/O write data |
| shutdown_cyc | input | 1 | Decoded shutdown special cycle, one cycle |
| kbc_rst_n | input | 1 | Asynchronous active-low reset request from the keyboard controller |
| bist_en | input | 1 | Self-test enable, captured on a full-reset request |
| init_n | output | 1 | Active-low processor initialization pulse |
| cpu_rst_req | output | 1 | One-cycle full processor reset request |
| cpu_rst_bist | output | 1 | Self-test enable captured with the last reset request |

## Verification
A stale port copy does not show up at once. It appears at the next write to that port, one edge later, as a missing pulse or an extra pulse. A wrong arm flag appears three edges after the keyboard-controller input next falls, again as a missing or extra pulse. A counter fault changes the width of the low pulse, so it shows as soon as `init_n` rises. The bench compares all three outputs against a behavioural model on every cycle, so any of these faults is reported in the cycle it reaches the ports.

// File: rtl/init_req_pkg.sv
package init_req_pkg;

  // One flag per trigger source seen at a clock edge
  typedef struct packed {
    logic shutdown;
    logic fast_port;
    logic rstc_port;
    logic kbc;
  } init_cause_t;

  function automatic logic any_cause(input init_cause_t c);
    return |c;
  endfunction

endpackage

// File: rtl/io_port_shadow.sv
module io_port_shadow #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rising
);

  logic              hit;
  logic [DATA_W-1:0] copy_q;

  assign hit    = wr_stb && (addr == PORT_ADDR);
  // bits turning on with this write, relative to the stored copy
  assign rising = hit ? (wdata & ~copy_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   copy_q <= '0;
    else if (hit) copy_q <= wdata;
  end

endmodule

// File: rtl/kbc_rearm.sv
module kbc_rearm #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic fire
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic         lvl;
  logic         seen_q;
  logic         armed_q;

  assign lvl  = sync_q[TOP];
  assign fire = armed_q && !lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      seen_q  <= 1'b1;
      armed_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[TOP-1:0], req_n_async};
      seen_q <= lvl;
      if (lvl && !seen_q) armed_q <= 1'b1;
      else if (fire)      armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic init_n
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
    else if (trigger)         remain_q <= CW'(PULSE_LEN);
  end

  assign init_n = (remain_q == '0);

endmodule

// File: rtl/init_req_gen.sv
module init_req_gen
  import init_req_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] FAST_PORT = 16'h0092,
  parameter logic [ADDR_W-1:0] RSTC_PORT = 16'h0CF9,
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              shutdown_cyc,
  input  logic              kbc_rst_n,
  input  logic              bist_en,
  output logic              init_n,
  output logic              cpu_rst_req,
  output logic              cpu_rst_bist
);

  // control bit positions decoded by software-visible layout
  localparam int FAST_BIT = 0;
  localparam int HOLD_BIT = 1;
  localparam int CPU_BIT  = 2;
  localparam int FULL_BIT = 3;

  logic [DATA_W-1:0] fast_rise;
  logic [DATA_W-1:0] rstc_rise;
  logic              kbc_fire;
  logic              full_req;
  init_cause_t       cause;

  io_port_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(FAST_PORT)) u_fast (
    .clk(clk), .rst_n(rst_n), .wr_stb(io_wr), .addr(io_addr), .wdata(io_wdata),
    .rising(fast_rise)
  );

  io_port_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(RSTC_PORT)) u_rstc (
    .clk(clk), .rst_n(rst_n), .wr_stb(io_wr), .addr(io_addr), .wdata(io_wdata),
    .rising(rstc_rise)
  );

  kbc_rearm #(.STAGES(SYNC_STAGES)) u_kbc (
    .clk(clk), .rst_n(rst_n), .req_n_async(kbc_rst_n), .fire(kbc_fire)
  );

  assign full_req = rstc_rise[CPU_BIT] && io_wdata[FULL_BIT];

  always_comb begin
    cause.shutdown  = shutdown_cyc;
    cause.fast_port = fast_rise[FAST_BIT];
    cause.rstc_port = rstc_rise[CPU_BIT] && !io_wdata[HOLD_BIT] && !io_wdata[FULL_BIT];
    cause.kbc       = kbc_fire;
  end

  init_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .trigger(any_cause(cause)), .init_n(init_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rst_req  <= 1'b0;
      cpu_rst_bist <= 1'b0;
    end else begin
      cpu_rst_req <= full_req;
      if (full_req) cpu_rst_bist <= bist_en;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{fast_rise[DATA_W-1:1], rstc_rise[DATA_W-1:3], rstc_rise[1:0],
                         io_wdata[DATA_W-1:4], io_wdata[2], io_wdata[0]};

endmodule

// File: rtl/init_req_chk.sv
module init_req_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic shutdown_cyc,
  input logic init_n,
  input logic cpu_rst_req,
  input logic cpu_rst_bist
);

  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= 0;
    else if (!init_n) low_run <= low_run + 1;
    else              low_run <= 0;
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_n) |-> (low_run == PULSE_LEN));

  // R9
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= PULSE_LEN);

  // R2
  shutdown_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_cyc && init_n) |=> !init_n);

  // R5
  rst_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_req |=> !cpu_rst_req);

  // R5
  bist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_req |-> $stable(cpu_rst_bist));

endmodule

bind init_req_gen init_req_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown_cyc(shutdown_cyc), .init_n(init_n),
  .cpu_rst_req(cpu_rst_req), .cpu_rst_bist(cpu_rst_bist)
);

// File: tb/sim_init_req_gen.sv
module sim_init_req_gen;

  localparam int PL  = 16;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        shutdown_cyc = 1'b0;
  logic        kbc_rst_n = 1'b1;
  logic        bist_en = 1'b0;
  logic        init_n, cpu_rst_req, cpu_rst_bist;

  int errs = 0, checks = 0;
  bit done = 0;

  init_req_gen u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .shutdown_cyc(shutdown_cyc), .kbc_rst_n(kbc_rst_n), .bist_en(bist_en),
    .init_n(init_n), .cpu_rst_req(cpu_rst_req), .cpu_rst_bist(cpu_rst_bist)
  );

  always #(CYC/2) clk = ~clk;

  // behavioural reference
  bit       m_k1, m_k2, m_k3, m_armed, m_req, m_bist;
  int       m_cnt;
  bit [7:0] m_fast, m_rstc;
  bit       f_any, f_kb, f_full, w_fast, w_rstc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_k1 = 1; m_k2 = 1; m_k3 = 1; m_armed = 1; m_req = 0; m_bist = 0;
      m_cnt = 0; m_fast = 0; m_rstc = 0;
    end else begin
      w_fast = io_wr && io_addr == 16'h0092;
      w_rstc = io_wr && io_addr == 16'h0CF9;
      f_kb   = m_armed && !m_k2;
      f_full = w_rstc && io_wdata[2] && !m_rstc[2] && io_wdata[3];
      f_any  = shutdown_cyc || f_kb ||
               (w_fast && io_wdata[0] && !m_fast[0]) ||
               (w_rstc && io_wdata[2] && !m_rstc[2] && !io_wdata[1] && !io_wdata[3]);
      if (w_fast) m_fast = io_wdata;
      if (w_rstc) m_rstc = io_wdata;
      if (m_k2 && !m_k3) m_armed = 1;
      else if (f_kb)     m_armed = 0;
      m_k3 = m_k2; m_k2 = m_k1; m_k1 = kbc_rst_n;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      else if (f_any) m_cnt = PL;
      m_req = f_full;
      if (f_full) m_bist = bist_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(init_n == (m_cnt == 0), "R8 init_n vs model", int'(init_n), int'(m_cnt == 0));
      chk(cpu_rst_req == m_req, "R5 cpu_rst_req vs model", int'(cpu_rst_req), int'(m_req));
      chk(cpu_rst_bist == m_bist, "R5 cpu_rst_bist vs model", int'(cpu_rst_bist), int'(m_bist));
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_wr = 1; io_addr = a; io_wdata = d;
    step();
    io_wr = 0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (!init_n && n < 1000) begin n++; step(); end
  endtask

  task automatic settle();
    repeat (PL + 3) step();
  endtask

  initial begin
    #(CYC * 200000);
    checks++; errs++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1;
    step();
    chk(init_n == 1, "R1 init_n after reset", int'(init_n), 1);
    chk(cpu_rst_req == 0, "R1 cpu_rst_req after reset", int'(cpu_rst_req), 0);
    chk(cpu_rst_bist == 0, "R1 cpu_rst_bist after reset", int'(cpu_rst_bist), 0);

    // shutdown cycle
    shutdown_cyc = 1; step(); shutdown_cyc = 0;
    chk(init_n == 0, "R2 shutdown starts pulse", int'(init_n), 0);
    low_len(n);
    chk(n == PL, "R8 pulse length", n, PL);
    step();

    // fast-init port
    io_write(16'h0092, 8'h01);
    chk(init_n == 0, "R3 bit0 rise starts pulse", int'(init_n), 0);
    settle();
    io_write(16'h0092, 8'h01);
    chk(init_n == 1, "R3 bit0 already set no pulse", int'(init_n), 1);
    io_write(16'h0092, 8'h00);
    chk(init_n == 1, "R3 bit0 clear no pulse", int'(init_n), 1);
    io_write(16'h0092, 8'h01);
    chk(init_n == 0, "R3 bit0 rise again", int'(init_n), 0);
    settle();

    // reset-control port
    io_write(16'h0CF9, 8'h04);
    chk(init_n == 0, "R4 bit2 rise starts pulse", int'(init_n), 0);
    settle();
    io_write(16'h0CF9, 8'h00);
    io_write(16'h0CF9, 8'h06);
    chk(init_n == 1, "R4 bit1 set blocks pulse", int'(init_n), 1);
    io_write(16'h0CF9, 8'h00);
    bist_en = 1;
    io_write(16'h0CF9, 8'h0C);
    chk(cpu_rst_req == 1, "R5 full reset strobe", int'(cpu_rst_req), 1);
    chk(cpu_rst_bist == 1, "R5 bist captured", int'(cpu_rst_bist), 1);
    chk(init_n == 1, "R5 full reset no pulse", int'(init_n), 1);
    bist_en = 0;
    step();
    chk(cpu_rst_req == 0, "R5 strobe one cycle", int'(cpu_rst_req), 0);
    step();
    chk(cpu_rst_bist == 1, "R5 bist held", int'(cpu_rst_bist), 1);
    io_write(16'h0CF9, 8'h00);

    // keyboard-controller input
    kbc_rst_n = 0;
    step(); step();
    chk(init_n == 1, "R6 synchronizer delay", int'(init_n), 1);
    step();
    chk(init_n == 0, "R6 kbc low starts pulse", int'(init_n), 0);
    settle();
    repeat (10) step();
    chk(init_n == 1, "R7 held low no retrigger", int'(init_n), 1);
    kbc_rst_n = 1;
    repeat (4) step();
    kbc_rst_n = 0;
    repeat (3) step();
    chk(init_n == 0, "R7 rearmed after high", int'(init_n), 0);
    settle();
    kbc_rst_n = 1;
    repeat (4) step();

    // absorption and shadow update
    io_write(16'h0092, 8'h00);
    chk(init_n == 1, "R10 clearing write no pulse", int'(init_n), 1);
    shutdown_cyc = 1; step(); shutdown_cyc = 0;
    kbc_rst_n = 0;
    io_write(16'h0092, 8'h01);
    low_len(n);
    chk(n == PL - 1, "R9 pulse not extended", n, PL - 1);
    repeat (4) step();
    chk(init_n == 1, "R9 absorbed kbc consumed", int'(init_n), 1);
    io_write(16'h0092, 8'h01);
    chk(init_n == 1, "R10 copy updated during pulse", int'(init_n), 1);
    io_write(16'h0093, 8'h00);
    io_write(16'h0092, 8'h01);
    chk(init_n == 1, "R10 other address ignored", int'(init_n), 1);
    kbc_rst_n = 1;
    repeat (4) step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule